// File: doc/BRIEF.md
# Display NMI Request and Status Logic

This block turns two timing strobes from a display controller into the non-maskable interrupt line of the CPU. The first strobe is a display-list request, raised when a flagged line ends. The second is a vertical-blank request, raised when vertical blank begins.

Each strobe sets a pending bit in a status register, whether or not its cause is enabled. Only a request whose cause is enabled at that moment starts an NMI. A bit that is already pending never fires later, even when its enable bit is turned on. Software that does not want interrupts can poll the status register and clear it with a clear strobe.

The NMI line is active low. It is driven as a pulse of fixed length, not held until the CPU acknowledges it. The CPU must therefore catch the falling edge. A CPU that is busy for the whole pulse can miss the interrupt.

Top module: `disp_nmi_ctrl`

## Requirements
- R1: In the enable write data, bit 7 enables display-list interrupts and bit 6 enables vertical-blank interrupts. A write takes effect at the clock edge on which `en_wr` is high, so it first governs the request one cycle later.
- R2: A request sets its pending bit one cycle later, whether or not that cause is enabled.
- R3: An NMI starts only from a request whose enable bit was already set when the request arrived. Setting an enable bit while a pending bit is held never pulls the line low.
- R4: A vertical-blank request clears the display-list pending bit and sets the vertical-blank pending bit. When both requests arrive on the same cycle, the result is vertical-blank pending only, and one NMI starts if vertical blank is enabled.
- R5: A `st_clr` strobe clears both pending bits. A request on the same cycle takes precedence over the clear for its own bit.
- R6: In the cycle after an enabled request, `nmi_n` goes low. It stays low for exactly PULSE_CYCLES cycles (default 4) and then returns high.
- R7: A request that arrives while the pulse is low does not lengthen the pulse or start a second one. It still updates the status bits.
- R8: The status read has bit 7 = display-list pending and bit 6 = vertical-blank pending. Bits 5 to 0 always read as 1.
- R9: After a synchronous reset, `nmi_n` is high, both pending bits are 0 and both enables are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dli_req | input | 1 | Display-list request strobe, one cycle |
| vbl_req | input | 1 | Vertical-blank request strobe, one cycle |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| st_clr | input | 1 | Status clear strobe |
| status_rd | output | 8 | Registered status read value |
| nmi_n | output | 1 | Active-low NMI pulse to the CPU |

## Verification
The bench uses the default PULSE_CYCLES of 4. With this value a request can be placed inside a pulse, and the exact cycle on which the pulse ends can be counted. This exercises the retrigger block and the re-arm that happens immediately after the pulse. The 8-bit data width puts the two enable bits and the two status bits at their fixed positions, 7 and 6. The stimulus mixes disabled requests, late enabling, simultaneous requests and a clear that collides with a request.

// File: rtl/disp_nmi_pkg.sv
package disp_nmi_pkg;
  localparam int DATA_W  = 8;
  localparam int DLI_BIT = 7;
  localparam int VBL_BIT = 6;
endpackage

// File: rtl/nmi_enable_reg.sv
module nmi_enable_reg
  import disp_nmi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              en_dli,
  output logic              en_vbl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_dli <= 1'b0;
      en_vbl <= 1'b0;
    end else if (wr) begin
      en_dli <= wdata[DLI_BIT];
      en_vbl <= wdata[VBL_BIT];
    end
  end
endmodule

// File: rtl/nmi_cause_status.sv
module nmi_cause_status
  import disp_nmi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              dli_req,
  input  logic              vbl_req,
  input  logic              clr,
  output logic [DATA_W-1:0] status
);
  logic dli_pend, vbl_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      dli_pend <= 1'b0;
      vbl_pend <= 1'b0;
    end else begin
      // vertical blank wins and wipes the display-list cause
      if (vbl_req)      dli_pend <= 1'b0;
      else if (dli_req) dli_pend <= 1'b1;
      else if (clr)     dli_pend <= 1'b0;

      if (vbl_req)      vbl_pend <= 1'b1;
      else if (clr)     vbl_pend <= 1'b0;
    end
  end

  always_comb begin
    status          = '1;
    status[DLI_BIT] = dli_pend;
    status[VBL_BIT] = vbl_pend;
  end
endmodule

// File: rtl/nmi_pulse_gen.sv
module nmi_pulse_gen #(
  parameter int PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic nmi_n
);
  localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES - 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_n  <= 1'b1;
      remain <= '0;
    end else if (nmi_n) begin
      if (fire) begin
        nmi_n  <= 1'b0;
        remain <= LOAD;
      end
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end else begin
      nmi_n <= 1'b1;
    end
  end
endmodule

// File: rtl/disp_nmi_ctrl.sv
module disp_nmi_ctrl
  import disp_nmi_pkg::*;
#(
  parameter int PULSE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dli_req,
  input  logic              vbl_req,
  input  logic              en_wr,
  input  logic [DATA_W-1:0] en_wdata,
  input  logic              st_clr,
  output logic [DATA_W-1:0] status_rd,
  output logic              nmi_n
);
  logic en_dli, en_vbl, fire;

  nmi_enable_reg u_en (
    .clk(clk), .rst(rst), .wr(en_wr), .wdata(en_wdata),
    .en_dli(en_dli), .en_vbl(en_vbl)
  );

  nmi_cause_status u_st (
    .clk(clk), .rst(rst), .dli_req(dli_req), .vbl_req(vbl_req),
    .clr(st_clr), .status(status_rd)
  );

  assign fire = (vbl_req & en_vbl) | (dli_req & en_dli & ~vbl_req)
              | (dli_req & vbl_req & en_vbl);

  nmi_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk(clk), .rst(rst), .fire(fire), .nmi_n(nmi_n)
  );
endmodule

// File: rtl/disp_nmi_ctrl_chk.sv
module disp_nmi_ctrl_chk
  import disp_nmi_pkg::*;
#(
  parameter int PULSE_CYCLES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              dli_req,
  input logic              vbl_req,
  input logic              st_clr,
  input logic              en_dli,
  input logic              en_vbl,
  input logic [DATA_W-1:0] status_rd,
  input logic              nmi_n
);
  int lowrun;
  always_ff @(posedge clk) begin
    if (rst)         lowrun <= 0;
    else if (!nmi_n) lowrun <= lowrun + 1;
    else             lowrun <= 0;
  end

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
    !nmi_n |-> lowrun < PULSE_CYCLES);  // R7
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_n) |-> lowrun == PULSE_CYCLES);  // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    $fell(nmi_n) |-> $past((vbl_req && en_vbl) || (dli_req && en_dli)));  // R3
  AST_VBL_WIPES_DLI: assert property (@(posedge clk) disable iff (rst)
    vbl_req |=> (status_rd[VBL_BIT] && !status_rd[DLI_BIT]));  // R4
  AST_DLI_RECORD: assert property (@(posedge clk) disable iff (rst)
    (dli_req && !vbl_req) |=> status_rd[DLI_BIT]);  // R2
  AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (st_clr && !dli_req && !vbl_req) |=> (status_rd[DLI_BIT:VBL_BIT] == 2'b00));  // R5
  AST_FILL_ONES: assert property (@(posedge clk) disable iff (rst)
    status_rd[VBL_BIT-1:0] == '1);  // R8
endmodule

bind disp_nmi_ctrl disp_nmi_ctrl_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .dli_req(dli_req), .vbl_req(vbl_req), .st_clr(st_clr),
  .en_dli(en_dli), .en_vbl(en_vbl), .status_rd(status_rd), .nmi_n(nmi_n)
);

// File: tb/tb_disp_nmi_ctrl.sv
module tb_disp_nmi_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dli_req = 1'b0, vbl_req = 1'b0, en_wr = 1'b0, st_clr = 1'b0;
  logic [7:0] en_wdata = 8'h00;
  logic [7:0] status_rd;
  logic       nmi_n;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  disp_nmi_ctrl dut (
    .clk(clk), .rst(rst), .dli_req(dli_req), .vbl_req(vbl_req),
    .en_wr(en_wr), .en_wdata(en_wdata), .st_clr(st_clr),
    .status_rd(status_rd), .nmi_n(nmi_n)
  );

  // row: {dli, vbl, ewr, en7, en6, clr, exp_dli_pend, exp_vbl_pend, exp_nmi_n}
  localparam logic [8:0] VEC [18] = '{
    9'b100000_101,  // R2 disabled request still recorded
    9'b001110_101,  // R3 enabling with pending: no NMI
    9'b000000_101,
    9'b000001_001,  // R5 clear
    9'b100000_100,  // R6 pulse starts
    9'b000000_100,
    9'b010000_010,  // R7 request during pulse, R4 wipes dli
    9'b000000_010,
    9'b000000_011,  // R6 released after 4 low cycles
    9'b110000_010,  // R4 simultaneous: vbl wins, one pulse
    9'b000000_010,
    9'b000000_010,
    9'b000000_010,
    9'b000000_011,
    9'b001010_011,  // R1 bit 7 off, bit 6 on
    9'b100000_111,  // R1 dli now disabled
    9'b100001_101,  // R5 request beats clear
    9'b010000_010   // R1 vbl still enabled, fires
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    dli_req = 0; vbl_req = 0; en_wr = 0; st_clr = 0;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R9 nmi", {31'd0, nmi_n}, 1);
    chk("R9 status", {24'd0, status_rd}, 32'h3F);
    for (int i = 0; i < 18; i++) begin
      dli_req  = VEC[i][8];
      vbl_req  = VEC[i][7];
      en_wr    = VEC[i][6];
      en_wdata = {VEC[i][5], VEC[i][4], 6'h00};
      st_clr   = VEC[i][3];
      @(negedge clk);
      chk($sformatf("R2/R4 row %0d status", i), {30'd0, status_rd[7:6]}, {30'd0, VEC[i][2:1]});
      chk($sformatf("R6 row %0d nmi", i), {31'd0, nmi_n}, {31'd0, VEC[i][0]});
      chk($sformatf("R8 row %0d fill", i), {26'd0, status_rd[5:0]}, 32'h3F);
    end
    // pulse from row 17: count low cycles, then re-arm directly after release
    begin
      int lows = 1;
      idle();
      while (!nmi_n && lows < 20) begin lows++; idle(); end
      chk("R6 pulse length", lows, 4);
    end
    vbl_req = 1; @(negedge clk);
    chk("R6 re-arm after release", {31'd0, nmi_n}, 0);
    repeat (4) idle();
    chk("R6 second pulse ended", {31'd0, nmi_n}, 1);
    // mid-run reset
    rst = 1; @(negedge clk); rst = 0;
    chk("R9 reset status", {24'd0, status_rd}, 32'h3F);
    vbl_req = 1; @(negedge clk); vbl_req = 0;
    chk("R9 enables cleared", {31'd0, nmi_n}, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule